// File: doc/BRIEF.md
# Page Write Buffer and Cycle Sequencer

This block sits between the serial front end and the non-volatile byte array of a 2048-byte memory that is arranged as 128 pages of 16 bytes. The front end announces a write operation with its 11-bit starting address. It then hands over the data bytes one at a time. The block stages these bytes in a 16-entry page buffer, and each entry carries its own valid flag. Consecutive bytes go to consecutive in-page offsets. The page number stays fixed, and the offset wraps inside the page.

Nothing reaches the array until the front end reports a valid STOP. On that STOP, if at least one byte is staged, the block starts a self-timed write cycle. It raises `busy` for exactly `CYCLE_CLKS` clocks. During the first 16 clocks of that cycle it plays the staged entries out over a simple write port, one per clock in ascending offset order, and writes only the valid ones. While `busy` is high the block ignores every front-end input, and the front end uses `busy` to keep the bus released. At the end of the cycle the buffer is emptied.

The top three locations of the address space are not general-purpose storage. 0x7FC and 0x7FD are reserved. 0x7FE holds a volatile control bit. 0x7FF holds the power-up setting byte, which is committed to the array only when the front end says the write is not volatile-only. A write that stages nothing starts no cycle.

Top module: `pwb_top`

## Requirements
- R1: After synchronous reset, `busy` and `arr_we` are low.
- R2: The data byte that arrives in position n of an operation starting at address A is written to array address {A[10:4], (A[3:0]+n) mod 16} with its original value.
- R3: When more bytes arrive than remain before the page end, the offset wraps to 0 of the same page, and a later byte to an offset replaces the earlier staged byte there.
- R4: `arr_we` pulses only for staged offsets. Offset j is written on the port j+1 clocks after the clock edge that samples the STOP, and offsets with no staged byte keep their old array contents.
- R5: Staged bytes produce no array write and no `busy` until a STOP is sampled.
- R6: A STOP with no staged byte leaves `busy` low, starts no cycle and writes nothing.
- R7: A STOP with staged bytes raises `busy` from the next clock for exactly `CYCLE_CLKS` clocks.
- R8: While `busy` is high, `op_begin`, `byte_we` and `stop_seen` have no effect. The buffer is empty after the cycle, so a later STOP with no new bytes starts nothing.
- R9: Bytes addressed to 0x7FC, 0x7FD or 0x7FE are never staged or written, but they still advance the offset.
- R10: A byte addressed to 0x7FF is staged only when `setting_vol_only` is low in the clock that delivers it.
- R11: An `op_begin` while idle discards all previously staged bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_begin | input | 1 | Start of a write operation; latches `op_addr` |
| op_addr | input | 11 | Starting byte address of the operation |
| byte_we | input | 1 | One data byte is delivered |
| byte_data | input | 8 | Data byte |
| stop_seen | input | 1 | Valid STOP condition observed |
| setting_vol_only | input | 1 | High: a byte to 0x7FF is volatile only and is not staged |
| busy | output | 1 | Internal write cycle in progress; bus must be ignored |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 11 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The hardest case to reach is front-end traffic that arrives while a cycle is already running. Such traffic includes a new operation, bytes and a second STOP. The array must then show only the earlier page's data, and a STOP after the cycle must find an empty buffer. The bench reaches this case by issuing a full operation while `busy` is high. Other scenarios cover the in-page wrap that overwrites a staged entry, and a run that starts at 0x7FC so that the skipped addresses are crossed by a live offset. The stimulus also toggles the volatile-only input on the last address.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int ADDR_W     = 11;
  localparam int BYTE_W     = 8;
  localparam int OFF_W      = 4;
  localparam int PAGE_W     = ADDR_W - OFF_W;
  localparam int PAGE_BYTES = 1 << OFF_W;

  localparam logic [ADDR_W-1:0] RSV_A     = 11'h7FC;
  localparam logic [ADDR_W-1:0] RSV_B     = 11'h7FD;
  localparam logic [ADDR_W-1:0] CTRL_LOC  = 11'h7FE;
  localparam logic [ADDR_W-1:0] SETUP_LOC = 11'h7FF;

  // true when a byte at this address must not reach the array
  function automatic logic skip_addr(input logic [ADDR_W-1:0] a, input logic vol_only);
    return (a == RSV_A) || (a == RSV_B) || (a == CTRL_LOC) ||
           ((a == SETUP_LOC) && vol_only);
  endfunction
endpackage

// File: rtl/pwb_stage.sv
module pwb_stage
  import pwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              op_begin,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              byte_we,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              vol_only,
  input  logic              rd_en,
  input  logic [OFF_W-1:0]  rd_idx,
  input  logic              clear,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [BYTE_W-1:0] arr_wdata,
  output logic              any_valid
);
  logic [BYTE_W-1:0]     buf_mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld;
  logic [PAGE_W-1:0]     page;
  logic [OFF_W-1:0]      ptr;
  logic                  take;

  assign take      = byte_we && !hold && !op_begin && !skip_addr({page, ptr}, vol_only);
  assign any_valid = |vld;

  // data storage: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (take) buf_mem[ptr] <= byte_data;
    if (rd_en) arr_wdata <= buf_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      page     <= '0;
      ptr      <= '0;
      arr_we   <= 1'b0;
      arr_addr <= '0;
    end else begin
      arr_we <= rd_en && vld[rd_idx];
      if (rd_en) arr_addr <= {page, rd_idx};
      if (clear) begin
        vld <= '0;
      end else if (!hold) begin
        if (op_begin) begin
          page <= op_addr[ADDR_W-1:OFF_W];
          ptr  <= op_addr[OFF_W-1:0];
          vld  <= '0;
        end else if (byte_we) begin
          if (take) vld[ptr] <= 1'b1;
          ptr <= ptr + 1'b1;
        end
      end
    end
  end

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(page)); // R8
endmodule

// File: rtl/pwb_seq.sv
module pwb_seq
  import pwb_pkg::*;
#(
  parameter int CYCLE_CLKS = 1200000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_seen,
  input  logic             any_valid,
  output logic             busy,
  output logic             rd_en,
  output logic [OFF_W-1:0] rd_idx,
  output logic             clear
);
  localparam int CNT_W = (CYCLE_CLKS > 2) ? $clog2(CYCLE_CLKS) : 2;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(CYCLE_CLKS - 1);
  localparam logic [CNT_W-1:0] PLAST = CNT_W'(PAGE_BYTES);

  logic [CNT_W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      tmr  <= '0;
    end else if (!busy) begin
      if (stop_seen && any_valid) begin
        busy <= 1'b1;
        tmr  <= '0;
      end
    end else if (tmr == LAST) begin
      busy <= 1'b0;
    end else begin
      tmr <= tmr + 1'b1;
    end
  end

  assign rd_en  = busy && (tmr < PLAST);
  assign rd_idx = tmr[OFF_W-1:0];
  assign clear  = busy && (tmr == LAST);

  AST_START_NEEDS_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_seen)); // R5
  AST_EMPTY_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && stop_seen && !any_valid) |=> !busy); // R6
endmodule

// File: rtl/pwb_top.sv
module pwb_top
  import pwb_pkg::*;
#(
  parameter int CYCLE_CLKS = 1200000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_begin,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              byte_we,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              stop_seen,
  input  logic              setting_vol_only,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [BYTE_W-1:0] arr_wdata
);
  logic             any_valid;
  logic             rd_en;
  logic [OFF_W-1:0] rd_idx;
  logic             clear;

  pwb_seq #(.CYCLE_CLKS(CYCLE_CLKS)) u_seq (
    .clk(clk), .rst(rst), .stop_seen(stop_seen), .any_valid(any_valid),
    .busy(busy), .rd_en(rd_en), .rd_idx(rd_idx), .clear(clear)
  );

  pwb_stage u_stage (
    .clk(clk), .rst(rst), .hold(busy), .op_begin(op_begin), .op_addr(op_addr),
    .byte_we(byte_we), .byte_data(byte_data), .vol_only(setting_vol_only),
    .rd_en(rd_en), .rd_idx(rd_idx), .clear(clear),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .any_valid(any_valid)
  );

  AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy); // R4
  AST_SKIP_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (arr_addr != RSV_A && arr_addr != RSV_B && arr_addr != CTRL_LOC)); // R9
endmodule

// File: tb/pwb_top_tb.sv
module pwb_top_tb;
  localparam int CYC = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_begin = 1'b0;
  logic [10:0] op_addr = '0;
  logic        byte_we = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        stop_seen = 1'b0;
  logic        setting_vol_only = 1'b0;
  logic        busy, arr_we;
  logic [10:0] arr_addr;
  logic [7:0]  arr_wdata;

  int checks = 0, errors = 0, rises = 0, ncyc = 0;
  bit done = 0;
  logic pb = 1'b0;

  pwb_top #(.CYCLE_CLKS(CYC)) u_dut (
    .clk(clk), .rst(rst), .op_begin(op_begin), .op_addr(op_addr),
    .byte_we(byte_we), .byte_data(byte_data), .stop_seen(stop_seen),
    .setting_vol_only(setting_vol_only), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  always #5 clk = ~clk;

  // array model written through the block's port
  logic [7:0] amem [2048];
  initial for (int i = 0; i < 2048; i++) amem[i] = 8'hEE;
  always @(posedge clk) if (!rst && arr_we) amem[arr_addr] <= arr_wdata;

  // behavioural reference model
  int  m_page, m_ptr, k;
  bit  m_busy, m_we;
  int  m_addr, m_data;
  bit  mv [16];
  int  md [16];

  function automatic bit skipped(int a, bit vo);
    return (a == 'h7FC) || (a == 'h7FD) || (a == 'h7FE) || (a == 'h7FF && vo);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_we = 0; m_page = 0; m_ptr = 0; k = 0;
      foreach (mv[i]) mv[i] = 0;
    end else begin
      m_we = 0;
      if (m_busy) begin
        if (k < 16) begin
          m_we = mv[k]; m_addr = m_page * 16 + k; m_data = md[k];
        end
        if (k == CYC - 1) begin
          m_busy = 0;
          foreach (mv[i]) mv[i] = 0;
        end else k++;
      end else begin
        bit anyv;
        if (op_begin) begin
          m_page = op_addr / 16; m_ptr = op_addr % 16;
          foreach (mv[i]) mv[i] = 0;
        end else if (byte_we) begin
          if (!skipped(m_page * 16 + m_ptr, setting_vol_only)) begin
            mv[m_ptr] = 1; md[m_ptr] = byte_data;
          end
          m_ptr = (m_ptr + 1) % 16;
        end
        anyv = 0;
        foreach (mv[i]) anyv |= mv[i];
        if (stop_seen && anyv) begin m_busy = 1; k = 0; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(busy == m_busy, "R7 busy", busy, m_busy);
      chk(arr_we == m_we, "R4 arr_we", arr_we, m_we);
      if (m_we && arr_we) begin
        chk(arr_addr == m_addr[10:0], "R2 arr_addr", arr_addr, m_addr);
        chk(arr_wdata == m_data[7:0], "R2 arr_wdata", arr_wdata, m_data);
      end
      if (busy && !pb) rises++;
      pb = busy;
    end
  end

  task automatic t_begin(input logic [10:0] a);
    @(negedge clk); op_begin = 1; op_addr = a;
    @(negedge clk); op_begin = 0;
  endtask
  task automatic t_byte(input logic [7:0] d);
    @(negedge clk); byte_we = 1; byte_data = d;
    @(negedge clk); byte_we = 0;
  endtask
  task automatic t_stop();
    @(negedge clk); stop_seen = 1;
    @(negedge clk); stop_seen = 0;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 4 * CYC && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(arr_we == 0, "R1 arr_we after reset", arr_we, 0);
    rst = 0;

    // R2: plain run inside a page
    t_begin(11'h120); t_byte(8'h11); t_byte(8'h22); t_byte(8'h33); t_stop();
    chk(busy == 1, "R7 busy after stop", busy, 1);
    wait_idle();
    chk(amem['h120] == 8'h11, "R2 byte0", amem['h120], 8'h11);
    chk(amem['h122] == 8'h33, "R2 byte2", amem['h122], 8'h33);
    chk(amem['h123] == 8'hEE, "R4 unstaged kept", amem['h123], 8'hEE);

    // R3: wrap from offset 14
    t_begin(11'h2FE);
    for (int i = 0; i < 4; i++) t_byte(8'hA0 + 8'(i));
    t_stop(); wait_idle();
    chk(amem['h2FF] == 8'hA1, "R3 last offset", amem['h2FF], 8'hA1);
    chk(amem['h2F0] == 8'hA2, "R3 wrapped offset0", amem['h2F0], 8'hA2);
    chk(amem['h300] == 8'hEE, "R3 next page untouched", amem['h300], 8'hEE);

    // R3: 17 bytes overwrite offset 0
    t_begin(11'h300);
    for (int i = 0; i < 17; i++) t_byte(8'(i));
    t_stop(); wait_idle();
    chk(amem['h300] == 8'h10, "R3 overwrite", amem['h300], 8'h10);
    chk(amem['h30F] == 8'h0F, "R3 page end", amem['h30F], 8'h0F);

    // R5, R11, R6: no stop, then restart, then empty stop
    rises = 0;
    t_begin(11'h400); t_byte(8'h55);
    repeat (60) @(negedge clk);
    chk(busy == 0 && rises == 0, "R5 no cycle without stop", rises, 0);
    chk(amem['h400] == 8'hEE, "R5 no write without stop", amem['h400], 8'hEE);
    t_begin(11'h410); t_stop();
    repeat (5) @(negedge clk);
    chk(rises == 0, "R6 empty stop no busy", rises, 0);
    chk(amem['h400] == 8'hEE, "R11 discarded byte", amem['h400], 8'hEE);

    // R8: traffic during busy is ignored
    rises = 0;
    t_begin(11'h500); t_byte(8'h66); t_stop();
    t_begin(11'h600); t_byte(8'h77); t_stop();
    wait_idle();
    t_stop();
    repeat (5) @(negedge clk);
    chk(rises == 1, "R8 one cycle only", rises, 1);
    chk(amem['h500] == 8'h66, "R8 first op written", amem['h500], 8'h66);
    chk(amem['h600] == 8'hEE, "R8 busy-time op dropped", amem['h600], 8'hEE);

    // R9, R10: top locations
    setting_vol_only = 0;
    t_begin(11'h7FC);
    for (int i = 1; i <= 4; i++) t_byte(8'(i));
    t_stop(); wait_idle();
    chk(amem['h7FC] == 8'hEE, "R9 7FC skipped", amem['h7FC], 8'hEE);
    chk(amem['h7FE] == 8'hEE, "R9 7FE skipped", amem['h7FE], 8'hEE);
    chk(amem['h7FF] == 8'h04, "R10 7FF staged", amem['h7FF], 8'h04);
    setting_vol_only = 1;
    rises = 0;
    t_begin(11'h7FF); t_byte(8'h09); t_stop();
    repeat (5) @(negedge clk);
    chk(rises == 0, "R10 volatile-only no cycle", rises, 0);
    chk(amem['h7FF] == 8'h04, "R10 7FF kept", amem['h7FF], 8'h04);
    t_begin(11'h7FB); t_byte(8'h05); t_byte(8'h06); t_stop(); wait_idle();
    chk(amem['h7FB] == 8'h05, "R9 7FB written", amem['h7FB], 8'h05);
    chk(amem['h7FC] == 8'hEE, "R9 7FC still skipped", amem['h7FC], 8'hEE);

    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 200000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 200000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule